// File: doc/BRIEF.md
# Statically Configured Streaming Switch

This block is a circuit-switched switch box for the static layer of a spatial accelerator interconnect. Every port carries a parameterised number of parallel links. Each link is called a lane, and lane `p*LINKS + k` is link `k` of port `p`. A static configuration word gives each output lane one source input lane, or marks the output lane unused. The switch makes no routing decisions at runtime. Several output lanes may name the same source, so a broadcast tree can branch inside a single switch.

Flow control is chosen at configuration time.

- **Per-hop mode:** each output lane has a one-entry register plus a skid entry. A stall from downstream reaches the upstream hop as a dropped `in_ready_o`.
- **End-to-end mode:** downstream readiness is ignored and data moves through the output register every cycle. Acknowledgement tokens returned by the destination on an output lane are forwarded, one cycle later, to that lane's source input lane.

Top module: `static_stream_switch`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `out_valid_o` and `ack_o` are all zero.
- R2: A word accepted on input lane i appears on every used output lane configured with source i one clock edge later. The source of output lane o is `cfg_src_i[o*SRC_W +: SRC_W]`.
- R3: In per-hop mode (`fc_mode_i`=0), an input lane that feeds several output lanes is accepted only when every one of those lanes can take a word. Each lane therefore receives each word exactly once, and never a repeated or skipped word.
- R4: In per-hop mode, an output lane holding a word with `out_ready_i` low keeps `out_valid_o` high and its data stable. It buffers one more word, and after that the source's `in_ready_o` goes low.
- R5: With all ready inputs high in per-hop mode, a lane passes one word per cycle with no bubbles.
- R6: In end-to-end mode (`fc_mode_i`=1), `out_ready_i` has no effect. `in_ready_o` is all ones, and each used output lane shows its source's valid and data one edge after they are driven.
- R7: In end-to-end mode, `ack_i` on a used output lane raises `ack_o` on its configured source lane one edge later. In per-hop mode `ack_o` stays zero.
- R8: An output lane with `cfg_used_i` low never drives `out_valid_o` high, and its `ack_i` is ignored.
- R9: An input lane that no used output lane selects reports `in_ready_o` high, so its words are sunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_mode_i | input | 1 | Flow-control mode: 0 per-hop, 1 end-to-end |
| cfg_src_i | input | LANES*SRC_W | Source input lane for each output lane |
| cfg_used_i | input | LANES | Output lane in use |
| in_valid_i | input | LANES | Input lane valid |
| in_data_i | input | LANES*DATA_W | Input lane data |
| in_ready_o | output | LANES | Input lane ready |
| out_valid_o | output | LANES | Output lane valid |
| out_data_o | output | LANES*DATA_W | Output lane data |
| out_ready_i | input | LANES | Output lane ready from downstream |
| ack_i | input | LANES | Acknowledgement token from downstream, per output lane |
| ack_o | output | LANES | Acknowledgement token to upstream, per input lane |

## Verification
A skid entry that is wrongly filled or cleared appears within one edge. It shows either as a repeated or lost word on the stalled output, or as a wrong `in_ready_o` on the source lane. A fanout lane that accepts a word without all of its branches being ready lets the branches drift apart: the free branch runs ahead, and the stalled branch later shows a word out of order. A wrong source selection or a broken end-to-end bypass shows on the very next edge, as the wrong data or the wrong valid pattern across the output lanes.

// File: rtl/sw_cfg_pkg.sv
package sw_cfg_pkg;
  typedef enum logic {
    FC_HOP = 1'b0,
    FC_E2E = 1'b1
  } fc_mode_e;
endpackage

// File: rtl/sw_lane_mux.sv
module sw_lane_mux #(
  parameter int LANES  = 8,
  parameter int DATA_W = 8,
  parameter int SRC_W  = 3
) (
  input  logic [SRC_W-1:0]        sel_i,
  input  logic [LANES-1:0]        valid_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [LANES-1:0]        ready_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    ready_o
);
  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    ready_o = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (sel_i == SRC_W'(i)) begin
        valid_o = valid_i[i];
        data_o  = data_i[i*DATA_W +: DATA_W];
        ready_o = ready_i[i];
      end
    end
  end
endmodule

// File: rtl/sw_out_stage.sv
module sw_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ready_i
);
  logic              main_v, skid_v;
  logic [DATA_W-1:0] main_d, skid_d;

  assign ready_o = !skid_v;
  assign valid_o = main_v;
  assign data_o  = main_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_v <= 1'b0;
      skid_v <= 1'b0;
      main_d <= '0;
      skid_d <= '0;
    end else if (!main_v || ready_i) begin
      if (skid_v) begin
        main_v <= 1'b1;
        main_d <= skid_d;
        skid_v <= 1'b0;
      end else begin
        main_v <= push_i;
        if (push_i) main_d <= data_i;
      end
    end else if (push_i) begin
      skid_v <= 1'b1;
      skid_d <= data_i;
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !skid_v);
endmodule

// File: rtl/sw_ack_return.sv
module sw_ack_return #(
  parameter int LANES = 8,
  parameter int SRC_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   e2e_i,
  input  logic [LANES-1:0]       used_i,
  input  logic [LANES*SRC_W-1:0] src_i,
  input  logic [LANES-1:0]       ack_i,
  output logic [LANES-1:0]       ack_o
);
  logic [LANES-1:0] ack_d;

  always_comb begin
    ack_d = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int o = 0; o < LANES; o++) begin
        if (used_i[o] && ack_i[o] && src_i[o*SRC_W +: SRC_W] == SRC_W'(i))
          ack_d[i] = e2e_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= '0;
    else         ack_o <= ack_d;
  end
endmodule

// File: rtl/static_stream_switch.sv
module static_stream_switch
  import sw_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LINKS     = 2,
  parameter int DATA_W    = 8,
  localparam int LANES    = NUM_PORTS * LINKS,
  localparam int SRC_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fc_mode_i,
  input  logic [LANES*SRC_W-1:0]  cfg_src_i,
  input  logic [LANES-1:0]        cfg_used_i,
  input  logic [LANES-1:0]        in_valid_i,
  input  logic [LANES*DATA_W-1:0] in_data_i,
  output logic [LANES-1:0]        in_ready_o,
  output logic [LANES-1:0]        out_valid_o,
  output logic [LANES*DATA_W-1:0] out_data_o,
  input  logic [LANES-1:0]        out_ready_i,
  input  logic [LANES-1:0]        ack_i,
  output logic [LANES-1:0]        ack_o
);
  if (LINKS < 1 || LINKS > 3) begin : g_bad_links
    $error("LINKS must be 1, 2 or 3");
  end

  fc_mode_e         fc_mode;
  logic             fc_e2e;
  logic [LANES-1:0] stage_rdy, stage_vld;

  assign fc_mode = fc_mode_e'(fc_mode_i);
  assign fc_e2e  = (fc_mode == FC_E2E);

  // An input advances only when every used output that selects it has room.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      in_ready_o[i] = 1'b1;
      for (int o = 0; o < LANES; o++) begin
        if (cfg_used_i[o] && cfg_src_i[o*SRC_W +: SRC_W] == SRC_W'(i))
          in_ready_o[i] = in_ready_o[i] & stage_rdy[o];
      end
    end
  end

  for (genvar o = 0; o < LANES; o++) begin : g_out
    logic              sel_v, sel_r, push;
    logic [DATA_W-1:0] sel_d;

    sw_lane_mux #(.LANES(LANES), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_mux (
      .sel_i   (cfg_src_i[o*SRC_W +: SRC_W]),
      .valid_i (in_valid_i),
      .data_i  (in_data_i),
      .ready_i (in_ready_o),
      .valid_o (sel_v),
      .data_o  (sel_d),
      .ready_o (sel_r)
    );

    assign push = cfg_used_i[o] && sel_v && sel_r;

    sw_out_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .data_i  (sel_d),
      .ready_o (stage_rdy[o]),
      .valid_o (stage_vld[o]),
      .data_o  (out_data_o[o*DATA_W +: DATA_W]),
      .ready_i (fc_e2e || out_ready_i[o])
    );

    assign out_valid_o[o] = stage_vld[o] && cfg_used_i[o];
  end

  sw_ack_return #(.LANES(LANES), .SRC_W(SRC_W)) u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .e2e_i  (fc_e2e),
    .used_i (cfg_used_i),
    .src_i  (cfg_src_i),
    .ack_i  (ack_i),
    .ack_o  (ack_o)
  );

  // R6
  e2e_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_e2e && $past(fc_e2e) |-> &in_ready_o);

  // R7
  ack_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |-> $past(fc_e2e));
endmodule

// File: tb/static_stream_switch_test.sv
`timescale 1ns/1ps
module static_stream_switch_test;
  localparam int L = 8;
  localparam int W = 8;
  localparam int S = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fc_mode_i = 1'b0;
  logic [L*S-1:0] cfg_src_i;
  logic [L-1:0]   cfg_used_i;
  logic [L-1:0]   in_valid_i = '0;
  logic [L*W-1:0] in_data_i = '0;
  logic [L-1:0]   in_ready_o, out_valid_o, ack_o;
  logic [L*W-1:0] out_data_o;
  logic [L-1:0]   out_ready_i = '1;
  logic [L-1:0]   ack_i = '0;

  int runs = 0, fails = 0;
  bit done = 0;

  // output lane -> source lane; lane 5 unused
  localparam int SRC [L] = '{0, 0, 3, 2, 5, 6, 7, 1};

  static_stream_switch uut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [W-1:0] od(int o);
    return out_data_o[o*W +: W];
  endfunction

  task automatic drive(int lane, logic v, logic [W-1:0] d);
    in_valid_i[lane]          = v;
    in_data_i[lane*W +: W]    = d;
  endtask

  // {input valid mask, expected output valid mask}
  localparam logic [15:0] VEC [7] = '{
    {8'hFF, 8'hDF}, {8'h01, 8'h03}, {8'h0C, 8'h0C}, {8'hA0, 8'h50},
    {8'h02, 8'h80}, {8'h40, 8'h00}, {8'h00, 8'h00}
  };

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      runs++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < L; o++) cfg_src_i[o*S +: S] = S'(SRC[o]);
    cfg_used_i = 8'b1101_1111;

    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 out_valid in reset", out_valid_o, 0);
    chk("R1 ack_o in reset", ack_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R1 out_valid after reset", out_valid_o, 0);
    chk("R1 ack_o after reset", ack_o, 0);

    // R2 R6 R8: end-to-end vectors, out_ready held low (ignored)
    @(negedge clk_i);
    fc_mode_i   = 1'b1;
    out_ready_i = '0;
    step();
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      for (int i = 0; i < L; i++) drive(i, VEC[k][8+i], W'(k*16 + 3 + i));
      step();
      chk("R6 in_ready all high", in_ready_o, 8'hFF);
      chk("R2 R8 out_valid pattern", out_valid_o, VEC[k][7:0]);
      for (int o = 0; o < L; o++)
        if (VEC[k][o]) chk("R2 out data from source", od(o), W'(k*16 + 3 + SRC[o]));
    end

    // R7 ack forwarding
    @(negedge clk_i);
    ack_i = 8'h04;
    step();
    chk("R7 ack to source lane 3", ack_o, 8'h08);
    @(negedge clk_i);
    ack_i = 8'h20;
    step();
    chk("R8 ack on unused lane ignored", ack_o, 8'h00);
    @(negedge clk_i);
    ack_i = 8'h02;
    step();
    chk("R7 ack from fanout branch", ack_o, 8'h01);
    @(negedge clk_i);
    fc_mode_i   = 1'b0;
    out_ready_i = '1;
    ack_i       = 8'h04;
    step();
    chk("R7 no ack in per-hop mode", ack_o, 8'h00);
    @(negedge clk_i);
    ack_i = '0;
    step();

    // R9 unselected inputs sink
    chk("R9 lane4 ready", in_ready_o[4], 1);
    chk("R9 lane6 ready", in_ready_o[6], 1);

    // R4 back pressure: lane2 -> out3
    @(negedge clk_i);
    out_ready_i[3] = 1'b0;
    drive(2, 1, 8'hA1);
    step();
    chk("R4 first word", {out_valid_o[3], od(3)}, {1'b1, 8'hA1});
    chk("R4 ready while skid empty", in_ready_o[2], 1);
    @(negedge clk_i);
    drive(2, 1, 8'hB2);
    step();
    chk("R4 hold under stall", od(3), 8'hA1);
    chk("R4 ready drops with skid full", in_ready_o[2], 0);
    @(negedge clk_i);
    drive(2, 1, 8'hC3);
    step();
    chk("R4 still held", {out_valid_o[3], od(3)}, {1'b1, 8'hA1});
    @(negedge clk_i);
    out_ready_i[3] = 1'b1;
    step();
    chk("R4 skid word next", od(3), 8'hB2);
    chk("R4 ready restored", in_ready_o[2], 1);
    step();
    chk("R4 blocked word after", od(3), 8'hC3);
    @(negedge clk_i);
    drive(2, 0, 8'h00);
    step();
    chk("R4 drained", out_valid_o[3], 0);

    // R3 fanout: lane0 -> out0, out1
    @(negedge clk_i);
    out_ready_i[1] = 1'b0;
    drive(0, 1, 8'hD4);
    step();
    chk("R3 both branches first", {od(0), od(1)}, {8'hD4, 8'hD4});
    @(negedge clk_i);
    drive(0, 1, 8'hE5);
    step();
    chk("R3 branches", {od(0), od(1)}, {8'hE5, 8'hD4});
    chk("R3 input held", in_ready_o[0], 0);
    @(negedge clk_i);
    drive(0, 1, 8'hF6);
    step();
    chk("R3 free branch waits", out_valid_o[1:0], 2'b10);
    chk("R3 stalled branch holds", od(1), 8'hD4);
    @(negedge clk_i);
    out_ready_i[1] = 1'b1;
    step();
    chk("R3 stalled branch catches up", {out_valid_o[1:0], od(1)}, {2'b10, 8'hE5});
    chk("R3 input ready again", in_ready_o[0], 1);
    step();
    chk("R3 both get next word", {out_valid_o[1:0], od(0), od(1)}, {2'b11, 8'hF6, 8'hF6});
    @(negedge clk_i);
    drive(0, 0, 8'h00);
    step();

    // R5 full throughput: lane1 -> out7
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      drive(1, 1, W'(8'h40 + k));
      step();
      chk("R5 word per cycle", {out_valid_o[7], od(7)}, {1'b1, W'(8'h40 + k)});
    end
    @(negedge clk_i);
    drive(1, 0, 8'h00);
    step();
    chk("R8 unused lane never valid", out_valid_o[5], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule